// File: doc/BRIEF.md
# Multi-Address I2C Write Slave

This block is the bus front end of a small peripheral. It watches an I2C bus through already filtered clock and data inputs and acknowledges write transfers that are addressed to it. It then stores the received bytes in a small register file and presents every register on a flat output bus. The block only accepts writes. A read request is never acknowledged. The block answers to more than one address. It always answers to a 7-bit hardware address taken from input pins. It can also answer to one group address and three sub-call addresses. Those four addresses are kept in registers of its own register file, and each one has its own enable bit. Any number of slaves on one bus may share a programmable address, and they all acknowledge together.

After the address byte, the first byte of a transfer loads a register pointer. Each byte after that is written to the register the pointer selects, and the pointer then advances. A mode bit decides when written bytes reach the visible registers. In one mode each byte lands as it is acknowledged. In the other mode, which is the default, bytes are collected in shadow storage and all of them land together at STOP. A general-call transfer that carries a fixed two-byte key puts every register back to its reset value.

Top module: `i2c_multi_slave`

## Requirements
- R1: After reset the registers hold: index 0 (mode) = 0x18, index 1 = 0xE2, index 2 = 0xE4, index 3 = 0xE8, index 4 = 0xE0, and every higher index = 0x00.
- R2: An address byte whose upper seven bits equal `hwAddr` and whose lowest bit is 0 (write) is acknowledged. The slave acknowledges by driving `sdaOe` high during the ninth clock of the byte, and it raises `sdaOe` only while SCL is low.
- R3: A read request (lowest address bit 1), or an address that matches nothing, is not acknowledged and changes no register.
- R4: The three sub-call addresses sit in bits 7:1 of registers 1, 2 and 3, and the group address sits in bits 7:1 of register 4. Mode bits 0, 1 and 2 enable the three sub-call addresses, and mode bit 3 enables the group address. A disabled address is not acknowledged.
- R5: A 7-bit address whose top four bits are 0000 or 1111 is never matched. This holds even when the hardware pins or a programmable address register hold such a value.
- R6: The first byte after the address loads the register pointer, taken modulo the register count. Each later byte is written to the register the pointer selects, and the pointer then increments, wrapping from the last register back to register 0.
- R7: While mode bit 4 is 1, written bytes do not appear on `regValues` until a STOP condition. A repeated START does not make them appear.
- R8: While mode bit 4 is 0, each written byte appears on `regValues` at the acknowledge of that byte, before STOP.
- R9: The general-call address 0x00 is acknowledged. If the next two bytes are 0xA5 and then 0x5A, every register returns to its R1 value. A byte that does not match the key is not acknowledged, and no register changes.
- R10: `regStrobe[i]` pulses for one cycle in the same cycle that register i is loaded. A register value never changes without its strobe. `sdaOe` never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Filtered bus clock level |
| sdaIn | input | 1 | Filtered bus data level |
| hwAddr | input | 7 | Hardware slave address from pins |
| sdaOe | output | 1 | High pulls SDA low (acknowledge) |
| regValues | output | NUM_REGS*8 | Visible register contents, register i at bits 8i+7:8i |
| regStrobe | output | NUM_REGS | One-cycle load pulse per register |

## Verification
Some properties are checked by assertions on every cycle. `sdaOe` may only move while SCL is low, and an acknowledge may only start while SCL is low. No register may change without its strobe. More than one strobe in the same cycle is allowed only for a STOP-time commit in STOP mode, or for a software reset that pulses all strobes. Other behaviour can only be shown by the bench's bus scenarios. These are the address matching for each source and enable, the rejection of reserved addresses, pointer wrap, the timing of held writes across a repeated START compared with per-byte updates, and key checking for the reset call.

// File: rtl/i2cms_pkg.sv
package i2cms_pkg;

  typedef struct packed {
    logic shiftIn;
    logic bitVal;
    logic loadPtr;
    logic writeByte;
    logic commit;
    logic swReset;
  } dpCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_HOLD} busState_t;

  typedef enum logic [2:0] {K_ADDR, K_PTR, K_DATA, K_KEY0, K_KEY1, K_NONE} byteKind_t;

  localparam logic [7:0] RST_KEY0 = 8'hA5;
  localparam logic [7:0] RST_KEY1 = 8'h5A;

  localparam int MODE_IDX      = 0;
  localparam int GROUP_IDX     = 4;
  localparam int NUM_SUB       = 3;
  localparam int EN_GROUP_BIT  = 3;
  localparam int STOP_MODE_BIT = 4;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      0:       return 8'h18;
      1:       return 8'hE2;
      2:       return 8'hE4;
      3:       return 8'hE8;
      4:       return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2cms_ctrl.sv
module i2cms_ctrl
  import i2cms_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   addrHit,
  input  logic   genCall,
  input  logic   keyMatch0,
  input  logic   keyMatch1,
  output dpCmd_t cmd,
  output logic   sdaOe
);

  logic [2:0] sclSync, sdaSync;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startSeen, stopSeen, byteDone;
  busState_t state;
  byteKind_t kind, kindAfter, nextKind;
  logic [3:0] bitCnt;
  logic ackNow, acked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 3'b111;
      sdaSync <= 3'b111;
    end else begin
      sclSync <= {sclSync[1:0], sclIn};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  assign sclNow    = sclSync[1];
  assign sclOld    = sclSync[2];
  assign sdaNow    = sdaSync[1];
  assign sdaOld    = sdaSync[2];
  assign sclRise   = sclNow && !sclOld;
  assign sclFall   = !sclNow && sclOld;
  assign startSeen = sclNow && sclOld && sdaOld && !sdaNow;
  assign stopSeen  = sclNow && sclOld && !sdaOld && sdaNow;
  assign byteDone  = (state == ST_RX) && sclFall && (bitCnt == 4'd8);

  always_comb begin
    ackNow    = 1'b0;
    kindAfter = K_NONE;
    case (kind)
      K_ADDR: begin
        ackNow    = addrHit || genCall;
        kindAfter = genCall ? K_KEY0 : K_PTR;
      end
      K_PTR:  begin ackNow = 1'b1;      kindAfter = K_DATA; end
      K_DATA: begin ackNow = 1'b1;      kindAfter = K_DATA; end
      K_KEY0: begin ackNow = keyMatch0; kindAfter = K_KEY1; end
      K_KEY1: begin ackNow = keyMatch1; kindAfter = K_NONE; end
      default: begin ackNow = 1'b0;     kindAfter = K_NONE; end
    endcase
  end

  always_comb begin
    cmd           = '0;
    cmd.shiftIn   = (state == ST_RX) && sclRise && (bitCnt < 4'd8);
    cmd.bitVal    = sdaNow;
    cmd.commit    = stopSeen;
    cmd.loadPtr   = byteDone && (kind == K_PTR);
    cmd.writeByte = byteDone && (kind == K_DATA);
    cmd.swReset   = byteDone && (kind == K_KEY1) && keyMatch1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      nextKind <= K_NONE;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
      acked    <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (cmd.shiftIn) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            state    <= ST_ACK;
            sdaOe    <= ackNow;
            acked    <= ackNow;
            nextKind <= kindAfter;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            kind   <= nextKind;
            state  <= acked ? ST_RX : ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cms_dpath.sv
module i2cms_dpath
  import i2cms_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic [6:0]            hwAddr,
  output logic                  addrHit,
  output logic                  genCall,
  output logic                  keyMatch0,
  output logic                  keyMatch1,
  output logic [NUM_REGS*8-1:0] regValues,
  output logic [NUM_REGS-1:0]   regStrobe
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0]       shiftReg;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       activeR [NUM_REGS];
  logic [7:0]       shadowR [NUM_REGS];
  logic [NUM_REGS-1:0] dirty;
  logic [6:0]       rxAddr;
  logic             reservedAddr, groupHit, stopMode;
  logic [NUM_SUB-1:0] subHit;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (cmd.shiftIn) shiftReg <= {shiftReg[6:0], cmd.bitVal};
  end

  assign rxAddr       = shiftReg[7:1];
  assign reservedAddr = (rxAddr[6:3] == 4'h0) || (rxAddr[6:3] == 4'hF);
  assign stopMode     = activeR[MODE_IDX][STOP_MODE_BIT];
  assign groupHit     = activeR[MODE_IDX][EN_GROUP_BIT] && (activeR[GROUP_IDX][7:1] == rxAddr);

  for (genvar k = 0; k < NUM_SUB; k++) begin : gSub
    assign subHit[k] = activeR[MODE_IDX][k] && (activeR[1+k][7:1] == rxAddr);
  end

  assign addrHit   = !shiftReg[0] && !reservedAddr &&
                     ((rxAddr == hwAddr) || groupHit || (|subHit));
  assign genCall   = (shiftReg == 8'h00);
  assign keyMatch0 = (shiftReg == RST_KEY0);
  assign keyMatch1 = (shiftReg == RST_KEY1);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.swReset) ptr <= '0;
    else if (cmd.loadPtr) ptr <= PTR_W'(shiftReg % NUM_REGS);
    else if (cmd.writeByte) ptr <= (ptr == PTR_W'(NUM_REGS-1)) ? '0 : ptr + 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic hitG;
    assign hitG = cmd.writeByte && (ptr == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeR[g]   <= regDefault(g);
        shadowR[g]   <= regDefault(g);
        dirty[g]     <= 1'b0;
        regStrobe[g] <= 1'b0;
      end else begin
        regStrobe[g] <= 1'b0;
        if (cmd.swReset) begin
          activeR[g]   <= regDefault(g);
          shadowR[g]   <= regDefault(g);
          dirty[g]     <= 1'b0;
          regStrobe[g] <= 1'b1;
        end else if (cmd.commit) begin
          if (dirty[g]) begin
            activeR[g]   <= shadowR[g];
            dirty[g]     <= 1'b0;
            regStrobe[g] <= 1'b1;
          end
        end else if (hitG) begin
          shadowR[g] <= shiftReg;
          if (stopMode) begin
            dirty[g] <= 1'b1;
          end else begin
            activeR[g]   <= shiftReg;
            regStrobe[g] <= 1'b1;
          end
        end
      end
    end

    assign regValues[g*8 +: 8] = activeR[g];
  end

endmodule

// File: rtl/i2c_multi_slave.sv
module i2c_multi_slave
  import i2cms_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [6:0]            hwAddr,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regValues,
  output logic [NUM_REGS-1:0]   regStrobe
);

  dpCmd_t cmd;
  logic addrHit, genCall, keyMatch0, keyMatch1;

  i2cms_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .genCall(genCall),
    .keyMatch0(keyMatch0), .keyMatch1(keyMatch1),
    .cmd(cmd), .sdaOe(sdaOe)
  );

  i2cms_dpath #(.NUM_REGS(NUM_REGS)) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hwAddr(hwAddr),
    .addrHit(addrHit), .genCall(genCall),
    .keyMatch0(keyMatch0), .keyMatch1(keyMatch1),
    .regValues(regValues), .regStrobe(regStrobe)
  );

endmodule

// File: rtl/i2cms_chk.sv
module i2cms_chk
  import i2cms_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regValues,
  input logic [NUM_REGS-1:0]   regStrobe
);

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

  // R2
  ack_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R7
  multi_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($countones(regStrobe) > 1) && !(&regStrobe)) |-> $past(regValues[MODE_IDX*8+STOP_MODE_BIT]));

  for (genvar g = 0; g < NUM_REGS; g++) begin : gStb
    // R10
    value_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regValues[g*8 +: 8]) |-> regStrobe[g]);
  end

endmodule

bind i2c_multi_slave i2cms_chk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regValues(regValues), .regStrobe(regStrobe)
);

// File: tb/sim_i2c_multi_slave.sv
`timescale 1ns/1ps
module sim_i2c_multi_slave;

  localparam int NR = 8;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [6:0] hwAddr = 7'h62;
  logic sdaOe, sdaBus;
  logic [NR*8-1:0] regValues;
  logic [NR-1:0] regStrobe;
  int nChk = 0, nFail = 0, strobe5 = 0;
  logic done = 1'b0;
  logic [7:0] expR [NR];

  always #2.5 clk = ~clk;
  assign sdaBus = sdaDrv & ~sdaOe;

  i2c_multi_slave #(.NUM_REGS(NR)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .hwAddr(hwAddr),
    .sdaOe(sdaOe), .regValues(regValues), .regStrobe(regStrobe)
  );

  always @(posedge clk) if (regStrobe[5]) strobe5++;

  // addr, ptr, data, ack expected, expected value at ptr afterwards
  localparam logic [39:0] VEC [7] = '{
    40'hC4_05_11_01_11,  // R2 hardware address
    40'hC4_07_22_01_22,  // R2
    40'hE0_06_33_01_33,  // R4 group enabled by default
    40'hE2_05_44_00_11,  // R4 sub-call disabled by default
    40'hC5_05_55_00_11,  // R3 read request
    40'hC6_05_66_00_11,  // R3 unmatched
    40'hE0_05_77_01_77   // R4
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rv(input int i);
    return regValues[i*8 +: 8];
  endfunction

  task automatic chkAll(input string req);
    for (int i = 0; i < NR; i++) chk(req, rv(i), expR[i]);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ(); sclDrv = 1'b1; waitQ(); sclDrv = 1'b0; waitQ();
    end
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    ackd = ~sdaBus;
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic writeTxn(input logic [7:0] a, input logic [7:0] p, input logic [7:0] d,
                          output logic ackd);
    logic x;
    busStart();
    sendByte(a, ackd);
    if (ackd) begin sendByte(p, x); sendByte(d, x); end
    busStop();
    waitQ();
  endtask

  task automatic resetModel();
    expR[0] = 8'h18; expR[1] = 8'hE2; expR[2] = 8'hE4; expR[3] = 8'hE8;
    expR[4] = 8'hE0;
    for (int i = 5; i < NR; i++) expR[i] = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic a, x;
    int s0;
    resetModel();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkAll("R1 reset values");
    chk("R1 sdaOe idle", {7'd0, sdaOe}, 8'h00);

    for (int i = 0; i < 7; i++) begin
      writeTxn(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], a);
      chk("R2/R3/R4 vector ack", {7'd0, a}, VEC[i][15:8]);
      chk("R2/R3/R4 vector value", rv(int'(VEC[i][26:24])), VEC[i][7:0]);
    end
    expR[5] = 8'h77; expR[6] = 8'h33; expR[7] = 8'h22;

    // R4 enable sub-call 1
    writeTxn(8'hC4, 8'h00, 8'h19, a); expR[0] = 8'h19;
    writeTxn(8'hE2, 8'h05, 8'h21, a); expR[5] = 8'h21;
    chk("R4 enabled sub-call ack", {7'd0, a}, 8'h01);
    chk("R4 sub-call write", rv(5), 8'h21);

    // R6 auto-increment with wrap
    busStart(); sendByte(8'hC4, a); sendByte(8'h07, x);
    sendByte(8'h99, x); sendByte(8'h1B, x); busStop(); waitQ();
    expR[7] = 8'h99; expR[0] = 8'h1B;
    chk("R6 pointer start", rv(7), 8'h99);
    chk("R6 pointer wrap", rv(0), 8'h1B);

    // R7 held until STOP, not on repeated START
    busStart(); sendByte(8'hC4, a); sendByte(8'h05, x); sendByte(8'h42, x);
    chk("R7 held before stop", rv(5), 8'h21);
    busStart(); sendByte(8'hC4, a);
    chk("R7 held after repeated start", rv(5), 8'h21);
    busStop(); waitQ(); expR[5] = 8'h42;
    chk("R7 commit at stop", rv(5), 8'h42);

    // R8 per-byte mode
    writeTxn(8'hC4, 8'h00, 8'h0B, a); expR[0] = 8'h0B;
    chk("R8 mode write", rv(0), 8'h0B);
    s0 = strobe5;
    busStart(); sendByte(8'hC4, a); sendByte(8'h05, x); sendByte(8'h55, x);
    chk("R8 visible before stop", rv(5), 8'h55);
    chk("R10 single strobe", 8'(strobe5 - s0), 8'h01);
    busStop(); waitQ(); expR[5] = 8'h55;

    // R5 reserved addresses
    writeTxn(8'hC4, 8'h04, 8'h08, a); expR[4] = 8'h08;
    writeTxn(8'h08, 8'h05, 8'hAA, a);
    chk("R5 reserved group address", {7'd0, a}, 8'h00);
    hwAddr = 7'h7A;
    writeTxn(8'hF4, 8'h05, 8'hAB, a);
    chk("R5 reserved hardware address", {7'd0, a}, 8'h00);
    chk("R5 no change", rv(5), 8'h55);
    hwAddr = 7'h62;

    // R4 group disable
    writeTxn(8'hC4, 8'h04, 8'hE0, a); expR[4] = 8'hE0;
    writeTxn(8'hE0, 8'h06, 8'h66, a); expR[6] = 8'h66;
    chk("R4 group ack", {7'd0, a}, 8'h01);
    writeTxn(8'hC4, 8'h00, 8'h03, a); expR[0] = 8'h03;
    writeTxn(8'hE0, 8'h06, 8'h77, a);
    chk("R4 group disabled nack", {7'd0, a}, 8'h00);
    chkAll("R4 state after disable");

    // R9 wrong key
    busStart(); sendByte(8'h00, a);
    chk("R9 general call ack", {7'd0, a}, 8'h01);
    sendByte(8'hA5, a);
    chk("R9 first key ack", {7'd0, a}, 8'h01);
    sendByte(8'h00, a);
    chk("R9 wrong key nack", {7'd0, a}, 8'h00);
    busStop(); waitQ();
    chkAll("R9 wrong key no change");

    // R9 correct key
    busStart(); sendByte(8'h00, a); sendByte(8'hA5, a); sendByte(8'h5A, a);
    chk("R9 second key ack", {7'd0, a}, 8'h01);
    busStop(); waitQ();
    resetModel();
    chkAll("R9 software reset values");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule